// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects interrupt causes into a status register and gates them with a mask register. The host reaches both registers through a simple write and read port. Single-cycle event pulses from the surrounding logic set status bits. The host acknowledges causes by writing ones to the status register. Every status bit that is set and not masked counts as pending, and any pending bit pulls the interrupt request low.

The request pin is active-low and open-drain. The block only controls when the pin is pulled low and leaves the high level to an external pull-up. Some hosts detect interrupts by edge. For them, a write that clears some pending causes but leaves others pending releases the request for exactly one clock and then pulls it low again, so the host sees a fresh falling edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status and mask registers read all zeros and `irq_oe_o` is 0 (request released).
- R2: An event bit high for one clock sets the matching status bit at that edge. A status read afterwards returns it.
- R3: A write to address 0 (status) clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same clock, the bit stays set.
- R5: `irq_oe_o` is 1 (pin driven low) in the clock after an edge that leaves at least one status bit set with its mask bit 0.
- R6: A mask bit of 1 keeps its status bit from driving the request. A write to address 1 (mask) takes effect on `irq_oe_o` at the same edge it is stored. Masking the only pending cause releases the request and leaves its status bit set.
- R7: If a status write clears at least one pending bit and at least one pending bit remains afterwards, `irq_oe_o` is 0 for exactly one clock and then 1 again.
- R8: Once a status write clears every pending bit, `irq_oe_o` goes to 0 and stays 0 until a new unmasked cause appears.
- R9: A mask write stores the data word, and a read with `rd_addr_i`=1 returns it. A read with `rd_addr_i`=0 returns the status register. Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | WIDTH | Per-cause set pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 status (write-one-to-clear), 1 mask |
| wr_data_i | input | WIDTH | Write data |
| rd_addr_i | input | 1 | Read select: 0 status, 1 mask |
| rd_data_o | output | WIDTH | Read data |
| irq_oe_o | output | 1 | Open-drain enable: 1 pulls the request pin low, 0 releases it |

## Verification
A corrupted status or mask bit shows at the read port in the same cycle. If that bit is unmasked, it also changes `irq_oe_o` at the next edge. A wrong decision on the release pulse shows as a missing gap, a gap that lasts two clocks, or a gap where nothing stays pending. Each of these is visible within two clocks of the clearing write. The sweep covers every combination of pending pattern, mask and clear pattern on a four-bit instance.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             irq_oe_o
);
  logic [WIDTH-1:0] status_q, mask_q;
  logic [WIDTH-1:0] clr_bits, status_d, mask_d, pend_now, pend_d, dropped;
  logic             partial_clr;

  assign clr_bits = (wr_en_i && !wr_addr_i) ? wr_data_i : '0;
  assign status_d = (status_q & ~clr_bits) | evt_i;
  assign mask_d   = (wr_en_i && wr_addr_i) ? wr_data_i : mask_q;

  assign pend_now = status_q & ~mask_q;
  assign pend_d   = status_d & ~mask_d;
  assign dropped  = pend_now & clr_bits & ~evt_i;

  assign partial_clr = (|dropped) && (|pend_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_oe_o <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_oe_o <= (|pend_d) && !partial_clr;
    end
  end

  assign rd_data_o = rd_addr_i ? mask_q : status_q;
endmodule

module irq_status_ctrl_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] evt_i,
  input logic             wr_en_i,
  input logic             wr_addr_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] status_q,
  input logic [WIDTH-1:0] mask_q,
  input logic             irq_oe_o
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_ZERO_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i) |=>
      ((status_q & $past(status_q) & ~$past(wr_data_i)) == ($past(status_q) & ~$past(wr_data_i)))); // R3

  AST_REQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe_o |-> (|(status_q & ~mask_q))); // R6

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(status_q & ~mask_q)) && !wr_en_i) |=> irq_oe_o); // R5

  AST_GAP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_oe_o) && (|(status_q & ~mask_q))) |-> $past(wr_en_i && !wr_addr_i)); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_oe_o); // R8
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt = '0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_addr = 1'b0;
  logic [W-1:0] rd_data;
  logic         irq_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_status_ctrl #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_oe_o(irq_oe)
  );

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic rd(input logic a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    #20;
    rd(1'b0, v); check("R1 status", v, 0);
    rd(1'b1, v); check("R1 mask", v, 0);
    check("R1 oe", int'(irq_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < N; m++) begin
        for (int w = 0; w < N; w++) begin
          int pend, rem, clr;
          wr(1'b0, '1);
          wr(1'b1, W'(m));
          evt = W'(s);
          step();
          pend = s & ~m;
          if (w == 0) begin
            rd(1'b0, v); check("R2 status set", v, s);
            rd(1'b1, v); check("R9 mask readback", v, m);
          end
          check("R5/R6 oe", int'(irq_oe), int'(pend != 0));
          wr(1'b0, W'(w));
          rem = pend & ~w;
          clr = pend & w;
          rd(1'b0, v); check("R3 w1c", v, s & ~w);
          check("R7/R8 oe after clear", int'(irq_oe), int'(rem != 0 && clr == 0));
          step();
          check("R7/R8 oe settled", int'(irq_oe), int'(rem != 0));
        end
      end
    end

    wr(1'b0, '1);
    wr(1'b1, '0);
    evt = 4'b0011;
    step();
    evt = 4'b0001; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 4'b0001;
    step();
    rd(1'b0, v); check("R4 set wins", v, 3);
    check("R4 no gap", int'(irq_oe), 1);

    wr(1'b0, '1);
    evt = 4'b0100;
    step();
    check("R5 oe", int'(irq_oe), 1);
    wr(1'b1, 4'b0100);
    check("R6 masked release", int'(irq_oe), 0);
    rd(1'b0, v); check("R6 status kept", v, 4);
    wr(1'b1, 4'b0000);
    check("R6 unmask", int'(irq_oe), 1);

    evt = 4'b1000;
    step();
    wr(1'b0, 4'b0100);
    check("R7 gap", int'(irq_oe), 0);
    step();
    check("R7 reassert", int'(irq_oe), 1);
    wr(1'b0, 4'b1000);
    check("R8 all cleared", int'(irq_oe), 0);
    step(); step();
    check("R8 stays", int'(irq_oe), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule